// File: doc/BRIEF.md
# Dual-Source Converter Clock Generator

This block produces the conversion timing for an analog-to-digital converter. Two clocks feed it: a free-running kernel clock with no phase relation to the bus, and the bus interface clock. A 2-bit source field selects where the conversion rate comes from. With the field at zero, a kernel-domain divider runs. That divider is set by a 4-bit prescaler code that picks one of twelve ratios between 1 and 256. With any other value, a bus-domain divider produces /1, /2 or /4 of the bus clock, and the prescaler plays no part.

Both configuration fields belong to the bus domain. They reach the kernel domain through a toggle request/acknowledge handshake with two-flop synchronizers. A divider picks up a new ratio only when its count wraps, so a change never shortens a period. Each divider has two outputs: a clock-enable pulse, one cycle per period, and a square-wave level. A bus-domain trigger input is routed according to the source field. In kernel mode it becomes a toggle, crosses two flops and is edge-detected into a single kernel pulse, so its timing carries synchronizer uncertainty. In bus mode it is registered once and comes out with a fixed one-cycle latency.

Top module: `adcclk_gen`

## Requirements
- R1: While reset is held and in the cycles after it, bus_ce, bus_div and bus_trig are low, and ker_trig is low. The kernel path starts in source mode 00 with prescaler code 0 (/1), so ker_ce and ker_div are high on every kernel cycle.
- R2: In source mode 00, prescaler codes 0..11 give kernel divide ratios 1, 2, 4, 6, 8, 10, 12, 16, 32, 64, 128 and 256 respectively. ker_ce pulses once, for one kernel cycle, every ratio cycles.
- R3: Prescaler codes 12..15 divide the kernel clock by 256.
- R4: For a ratio N of 2 or more, the divider level (ker_div or bus_div) is high for N/2 cycles of each N-cycle period, starting in the cycle after the enable pulse. For N = 1 it stays high.
- R5: Source mode 01 gives a bus_ce period of 1 bus cycle, mode 10 a period of 2 and mode 11 a period of 4.
- R6: In mode 00, bus_ce and bus_div stay low. In a nonzero mode, once the setting has crossed, ker_ce and ker_div stay low.
- R7: Changing the prescaler code while a bus mode is selected leaves the bus_ce period unchanged.
- R8: A configuration crosses to the kernel domain through a request/acknowledge handshake. The captured copy is held stable while a request is outstanding. A divider never changes its ratio except at a count wrap, and after a wrap its count restarts at 0.
- R9: In mode 00, a one-cycle trig_in produces exactly one single-cycle ker_trig pulse and no bus_trig.
- R10: In a nonzero mode, a one-cycle trig_in produces bus_trig exactly one bus cycle later and no ker_trig.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_bus | input | 1 | Bus interface clock |
| rst_bus | input | 1 | Synchronous active-high reset, bus domain |
| clk_ker | input | 1 | Asynchronous kernel clock |
| rst_ker | input | 1 | Synchronous active-high reset, kernel domain |
| cfg_mode | input | 2 | Source field: 00 kernel, 01 bus/1, 10 bus/2, 11 bus/4 |
| cfg_presc | input | 4 | Kernel prescaler code |
| trig_in | input | 1 | Conversion trigger pulse, bus domain |
| ker_ce | output | 1 | Kernel-domain conversion clock-enable |
| ker_div | output | 1 | Kernel-domain divided clock level |
| ker_trig | output | 1 | Trigger pulse in the kernel domain |
| bus_ce | output | 1 | Bus-domain conversion clock-enable |
| bus_div | output | 1 | Bus-domain divided clock level |
| bus_trig | output | 1 | Trigger pulse with fixed latency, bus domain |

## Verification
The hardest case to reach from the ports is a kernel ratio change arriving in the middle of a long period. The new value has to cross the handshake first and then wait for the old count to wrap. The bench steps through all sixteen prescaler codes in order, each straight after the previous one, including the run up to the /256 codes. It allows a settling window longer than one full old period plus the crossing delay. It then checks four consecutive periods and the high time in each, so a truncated or merged period shows up as a wrong gap.

// File: rtl/adcclk_pkg.sv
package adcclk_pkg;

    localparam int MAX_DIV = 256;
    localparam int CNT_W   = $clog2(MAX_DIV + 1);

    typedef enum logic [1:0] {
        SRC_KER  = 2'b00,
        SRC_BUS1 = 2'b01,
        SRC_BUS2 = 2'b10,
        SRC_BUS4 = 2'b11
    } src_mode_e;

    typedef struct packed {
        src_mode_e  mode;
        logic [3:0] presc;
    } clk_cfg_t;

    localparam clk_cfg_t CFG_RESET = '{mode: SRC_KER, presc: 4'd0};

    function automatic logic [CNT_W-1:0] presc_ratio(input logic [3:0] code);
        logic [CNT_W-1:0] r;
        case (code)
            4'd0:    r = CNT_W'(1);
            4'd1:    r = CNT_W'(2);
            4'd2:    r = CNT_W'(4);
            4'd3:    r = CNT_W'(6);
            4'd4:    r = CNT_W'(8);
            4'd5:    r = CNT_W'(10);
            4'd6:    r = CNT_W'(12);
            4'd7:    r = CNT_W'(16);
            4'd8:    r = CNT_W'(32);
            4'd9:    r = CNT_W'(64);
            4'd10:   r = CNT_W'(128);
            default: r = CNT_W'(256);
        endcase
        return r;
    endfunction

    function automatic logic [CNT_W-1:0] bus_ratio(input src_mode_e m);
        logic [CNT_W-1:0] r;
        case (m)
            SRC_BUS2: r = CNT_W'(2);
            SRC_BUS4: r = CNT_W'(4);
            default:  r = CNT_W'(1);
        endcase
        return r;
    endfunction

endpackage

// File: rtl/adcclk_divider.sv
module adcclk_divider
    import adcclk_pkg::*;
#(
    parameter int W = CNT_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         en,
    input  logic [W-1:0] ratio_in,
    output logic         ce,
    output logic         div
);

    logic [W-1:0] cnt_q;
    logic [W-1:0] cur_q;
    logic         wrap;

    assign wrap = (cnt_q == cur_q - W'(1));

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
            cur_q <= W'(1);
        end else if (!en || wrap) begin
            cnt_q <= '0;
            cur_q <= (ratio_in == '0) ? W'(1) : ratio_in;
        end else begin
            cnt_q <= cnt_q + W'(1);
        end
    end

    assign ce  = en && wrap;
    assign div = en && ((cur_q == W'(1)) || (cnt_q < (cur_q >> 1)));

    // R8: count restarts after each wrap
    p_wrap_restart_r8: assert property (@(posedge clk) disable iff (rst)
        (en && wrap) |=> (cnt_q == '0));

    // R8: ratio only changes at a wrap while running
    p_ratio_hold_r8: assert property (@(posedge clk) disable iff (rst)
        (en && !wrap) |=> $stable(cur_q));

    // R2: count stays inside the current period
    p_cnt_bound_r2: assert property (@(posedge clk) disable iff (rst)
        cnt_q < cur_q);

endmodule

// File: rtl/adcclk_cfg_cdc.sv
module adcclk_cfg_cdc
    import adcclk_pkg::*;
(
    input  logic     clk_bus,
    input  logic     rst_bus,
    input  logic     clk_ker,
    input  logic     rst_ker,
    input  clk_cfg_t cfg_bus,
    output clk_cfg_t cfg_ker
);

    clk_cfg_t sent_q;
    logic     req_q;
    logic     ack_s1_q, ack_s2_q;
    logic     busy;

    logic     req_s1_q, req_s2_q;
    logic     ack_q;
    clk_cfg_t ker_q;

    assign busy = (req_q != ack_s2_q);

    always_ff @(posedge clk_bus) begin
        if (rst_bus) begin
            sent_q   <= CFG_RESET;
            req_q    <= 1'b0;
            ack_s1_q <= 1'b0;
            ack_s2_q <= 1'b0;
        end else begin
            ack_s1_q <= ack_q;
            ack_s2_q <= ack_s1_q;
            if (!busy && (cfg_bus != sent_q)) begin
                sent_q <= cfg_bus;
                req_q  <= ~req_q;
            end
        end
    end

    always_ff @(posedge clk_ker) begin
        if (rst_ker) begin
            req_s1_q <= 1'b0;
            req_s2_q <= 1'b0;
            ack_q    <= 1'b0;
            ker_q    <= CFG_RESET;
        end else begin
            req_s1_q <= req_q;
            req_s2_q <= req_s1_q;
            if (req_s2_q != ack_q) begin
                ker_q <= sent_q;
                ack_q <= req_s2_q;
            end
        end
    end

    assign cfg_ker = ker_q;

    // R8: captured setting held while a request is outstanding
    p_hold_stable_r8: assert property (@(posedge clk_bus) disable iff (rst_bus)
        busy |=> $stable(sent_q));

endmodule

// File: rtl/adcclk_trig_sync.sv
module adcclk_trig_sync (
    input  logic clk_bus,
    input  logic rst_bus,
    input  logic clk_ker,
    input  logic rst_ker,
    input  logic fire,
    output logic pulse
);

    logic tgl_q;
    logic s1_q, s2_q, s3_q;

    always_ff @(posedge clk_bus) begin
        if (rst_bus) tgl_q <= 1'b0;
        else if (fire) tgl_q <= ~tgl_q;
    end

    always_ff @(posedge clk_ker) begin
        if (rst_ker) begin
            s1_q <= 1'b0;
            s2_q <= 1'b0;
            s3_q <= 1'b0;
        end else begin
            s1_q <= tgl_q;
            s2_q <= s1_q;
            s3_q <= s2_q;
        end
    end

    assign pulse = s2_q ^ s3_q;

endmodule

// File: rtl/adcclk_gen.sv
module adcclk_gen
    import adcclk_pkg::*;
(
    input  logic       clk_bus,
    input  logic       rst_bus,
    input  logic       clk_ker,
    input  logic       rst_ker,
    input  logic [1:0] cfg_mode,
    input  logic [3:0] cfg_presc,
    input  logic       trig_in,
    output logic       ker_ce,
    output logic       ker_div,
    output logic       ker_trig,
    output logic       bus_ce,
    output logic       bus_div,
    output logic       bus_trig
);

    clk_cfg_t  cfg_bus;
    clk_cfg_t  cfg_ker;
    src_mode_e mode_bus;
    logic      bus_sel;
    logic      bus_trig_q;

    assign mode_bus = src_mode_e'(cfg_mode);
    assign cfg_bus  = '{mode: mode_bus, presc: cfg_presc};
    assign bus_sel  = (mode_bus != SRC_KER);

    adcclk_cfg_cdc u_cdc (
        .clk_bus (clk_bus),
        .rst_bus (rst_bus),
        .clk_ker (clk_ker),
        .rst_ker (rst_ker),
        .cfg_bus (cfg_bus),
        .cfg_ker (cfg_ker)
    );

    adcclk_divider #(.W(CNT_W)) u_ker_div (
        .clk      (clk_ker),
        .rst      (rst_ker),
        .en       (cfg_ker.mode == SRC_KER),
        .ratio_in (presc_ratio(cfg_ker.presc)),
        .ce       (ker_ce),
        .div      (ker_div)
    );

    adcclk_divider #(.W(CNT_W)) u_bus_div (
        .clk      (clk_bus),
        .rst      (rst_bus),
        .en       (bus_sel),
        .ratio_in (bus_ratio(mode_bus)),
        .ce       (bus_ce),
        .div      (bus_div)
    );

    adcclk_trig_sync u_trig (
        .clk_bus (clk_bus),
        .rst_bus (rst_bus),
        .clk_ker (clk_ker),
        .rst_ker (rst_ker),
        .fire    (trig_in && !bus_sel),
        .pulse   (ker_trig)
    );

    always_ff @(posedge clk_bus) begin
        if (rst_bus) bus_trig_q <= 1'b0;
        else         bus_trig_q <= trig_in && bus_sel;
    end

    assign bus_trig = bus_trig_q;

    // R10: fixed one-cycle trigger latency in bus mode
    p_bus_trig_lat_r10: assert property (@(posedge clk_bus) disable iff (rst_bus)
        (trig_in && (cfg_mode != 2'b00)) |=> bus_trig);

    // R9: no bus-side trigger when the kernel source is selected
    p_bus_trig_quiet_r9: assert property (@(posedge clk_bus) disable iff (rst_bus)
        (trig_in && (cfg_mode == 2'b00)) |=> !bus_trig);

endmodule

// File: tb/sim_adcclk_gen.sv
module sim_adcclk_gen;

    logic       clk_bus = 1'b0;
    logic       clk_ker = 1'b0;
    logic       rst_bus = 1'b1;
    logic       rst_ker = 1'b1;
    logic [1:0] cfg_mode = 2'b00;
    logic [3:0] cfg_presc = 4'd0;
    logic       trig_in = 1'b0;
    logic       ker_ce, ker_div, ker_trig, bus_ce, bus_div, bus_trig;

    int checks = 0;
    int errors = 0;
    int n_ktrig = 0;
    int n_btrig = 0;

    always #2.5 clk_bus = ~clk_bus;
    always #3.5 clk_ker = ~clk_ker;

    adcclk_gen u0 (
        .clk_bus(clk_bus), .rst_bus(rst_bus), .clk_ker(clk_ker), .rst_ker(rst_ker),
        .cfg_mode(cfg_mode), .cfg_presc(cfg_presc), .trig_in(trig_in),
        .ker_ce(ker_ce), .ker_div(ker_div), .ker_trig(ker_trig),
        .bus_ce(bus_ce), .bus_div(bus_div), .bus_trig(bus_trig)
    );

    always @(negedge clk_ker) if (!rst_ker && ker_trig) n_ktrig++;
    always @(negedge clk_bus) if (!rst_bus && bus_trig) n_btrig++;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int exp_presc(input int c);
        if (c == 0) return 1;
        if (c <= 6) return 2 * c;
        if (c >= 11) return 256;
        return 16 << (c - 7);
    endfunction

    task automatic step(input bit ker);
        if (ker) @(negedge clk_ker);
        else     @(negedge clk_bus);
    endtask

    // measure four periods of ce and div high time
    task automatic measure(input bit ker, input int ratio, input string req);
        int t = 0;
        int exp_hi;
        exp_hi = (ratio == 1) ? 1 : ratio / 2;
        do begin
            step(ker);
            t++;
        end while (!(ker ? ker_ce : bus_ce) && t < 2000);
        chk(t < 2000, req, t, 0);
        for (int p = 0; p < 4; p++) begin
            int gap = 0;
            int hi = 0;
            do begin
                step(ker);
                gap++;
                if (ker ? ker_div : bus_div) hi++;
            end while (!(ker ? ker_ce : bus_ce) && gap < 2000);
            chk(gap == ratio, req, gap, ratio);
            chk(hi == exp_hi, "R4", hi, exp_hi);
        end
    endtask

    task automatic settle_ker();
        repeat (30) @(negedge clk_bus);
        repeat (600) @(negedge clk_ker);
    endtask

    task automatic fire();
        @(negedge clk_bus);
        trig_in = 1'b1;
        @(negedge clk_bus);
        trig_in = 1'b0;
    endtask

    initial begin
        #900000;
        errors++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int kb, bb;
        repeat (3) @(negedge clk_bus);
        chk(!bus_ce && !bus_div && !bus_trig, "R1 bus during reset", bus_ce, 0);
        rst_bus = 1'b0;
        @(negedge clk_ker);
        rst_ker = 1'b0;
        repeat (3) @(negedge clk_ker);
        chk(ker_ce == 1'b1, "R1 ker_ce", ker_ce, 1);
        chk(ker_div == 1'b1, "R1 ker_div", ker_div, 1);
        chk(ker_trig == 1'b0, "R1 ker_trig", ker_trig, 0);
        @(negedge clk_bus);
        chk(!bus_ce && !bus_div && !bus_trig, "R1 bus after reset", bus_div, 0);

        // R2 R3: sweep all prescaler codes in kernel mode
        for (int c = 0; c < 16; c++) begin
            cfg_presc = 4'(c);
            settle_ker();
            measure(1'b1, exp_presc(c), c < 12 ? "R2" : "R3");
        end
        // R6: bus path quiet in kernel mode
        bb = 0;
        repeat (50) begin
            @(negedge clk_bus);
            if (bus_ce || bus_div) bb++;
        end
        chk(bb == 0, "R6 bus quiet", bb, 0);

        // R5: bus modes
        for (int m = 1; m < 4; m++) begin
            cfg_mode = 2'(m);
            measure(1'b0, 1 << (m - 1), "R5");
        end
        settle_ker();
        kb = 0;
        repeat (300) begin
            @(negedge clk_ker);
            if (ker_ce || ker_div) kb++;
        end
        chk(kb == 0, "R6 ker quiet", kb, 0);

        // R7: prescaler has no effect in bus mode
        cfg_mode = 2'b10;
        for (int c = 0; c < 16; c += 5) begin
            @(negedge clk_bus);
            cfg_presc = 4'(c);
            measure(1'b0, 2, "R7");
        end

        // R10: bus-mode trigger with fixed latency
        for (int k = 0; k < 3; k++) begin
            kb = n_ktrig;
            @(negedge clk_bus);
            trig_in = 1'b1;
            @(negedge clk_bus);
            trig_in = 1'b0;
            chk(bus_trig == 1'b1, "R10 latency", bus_trig, 1);
            @(negedge clk_bus);
            chk(bus_trig == 1'b0, "R10 single", bus_trig, 0);
            repeat (20 + k) @(negedge clk_ker);
            chk(n_ktrig == kb, "R10 no ker_trig", n_ktrig - kb, 0);
        end

        // R9: kernel-mode trigger through resync
        cfg_mode = 2'b00;
        cfg_presc = 4'd1;
        settle_ker();
        for (int k = 0; k < 3; k++) begin
            kb = n_ktrig;
            bb = n_btrig;
            fire();
            repeat (20 + 3 * k) @(negedge clk_ker);
            chk(n_ktrig - kb == 1, "R9 one ker_trig", n_ktrig - kb, 1);
            chk(n_btrig == bb, "R9 no bus_trig", n_btrig - bb, 0);
        end
        measure(1'b1, 2, "R8 after triggers");

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule